// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a simple in-order CPU core stops and enters debug mode. It watches the core reset and an active-low external debug request pin. It also watches a debug-request bit that a host write sets, an enable for the on-chip debug logic, and the core's status: instruction completed, instruction register loaded, and a vector of low-power states. From these it drives a halt output to the core, a clock-enable/wake output and a DEBUG status bit. The host polls the DEBUG bit as its acknowledge.

There are four ways in. A request held through core reset release stops the core before its first instruction. So does a register request raised while the core is in reset. A request during normal execution lets the current instruction finish and then stops the core when the next fetched instruction reaches the instruction register. A request while the core reports a low-power state first turns the clocks back on. After an entry from reset, a flag tells the host that reset exception processing was skipped. A go command leaves debug mode.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: With `dbg_en_i` low, no request of any kind causes entry. `halt_o`, `debug_o` and `wake_o` stay 0. A register request is not stored, so `req_pend_o` stays 0. An entry already under way and not yet complete is abandoned when `dbg_en_i` falls.
- R2: If `ext_req_ni` is low in the cycle `cpu_rst_ni` returns high, `debug_o`, `halt_o` and `rst_skip_o` are 1 one clock later. No completion or fetch input is needed.
- R3: A register request raised while `cpu_rst_ni` is low is held in `req_pend_o`. At reset release it gives the same entry as R2, with `rst_skip_o` set to 1.
- R4: A request during normal execution first waits for an `instr_done_i` pulse, then for a later `ir_loaded_i` pulse. `debug_o` and `halt_o` rise one clock after that `ir_loaded_i`.
- R5: An `ir_loaded_i` pulse seen before the current instruction completes does not stop the core. Any `ir_loaded_i` after completion stops it, whatever caused that fetch.
- R6: After controller reset, all outputs are 0. While in debug mode, `halt_o`, `debug_o` and `wake_o` are 1. A `go_i` pulse clears `debug_o`, `halt_o`, `wake_o` and `rst_skip_o` one clock later, and the core returns to running.
- R7: A request while any bit of `lp_i` is set (bit 0 waiting, bit 1 halted, bit 2 stopped) raises `wake_o` first. `debug_o` rises one clock after `clk_run_i` is sampled high.
- R8: `rst_skip_o` stays 0 for entries made outside reset.
- R9: The pending register request clears on the clock that enters debug mode, so a later `go_i` does not cause a fresh entry.
- R10: An external and a register request arriving in the same cycle give exactly one rise of `debug_o`.

Bench timing note: a register request set by `reg_req_set_i` appears on `req_pend_o` one clock later, and is acted on from that registered bit. The external pin acts in the clock it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Controller asynchronous reset, active low |
| cpu_rst_ni | input | 1 | Core reset being watched, active low |
| dbg_en_i | input | 1 | On-chip debug logic enable |
| ext_req_ni | input | 1 | External debug request pin, active low |
| reg_req_set_i | input | 1 | Host write that sets the debug-request bit |
| go_i | input | 1 | Host go command, leaves debug mode |
| instr_done_i | input | 1 | Current instruction completed |
| ir_loaded_i | input | 1 | Fetched instruction loaded into the instruction register |
| lp_i | input | LpW | Low-power status: bit 0 waiting, bit 1 halted, bit 2 stopped |
| clk_run_i | input | 1 | Core clocks reported running |
| halt_o | output | 1 | Freeze the core |
| wake_o | output | 1 | Clock enable / wake request to the core |
| debug_o | output | 1 | DEBUG status bit, host acknowledge |
| rst_skip_o | output | 1 | Entered from reset; reset exception processing was skipped |
| req_pend_o | output | 1 | Pending debug-request bit |

## Verification
The hardest case to reach is a normal-execution request where fetches and completions come in the wrong order. The bench pulses `ir_loaded_i` before `instr_done_i` and checks that no halt follows. Only then does it supply the completion and a fresh load. The low-power path is also held open: `clk_run_i` is kept low for several cycles and then released, and the bench checks the exact cycle of entry. The simultaneous external and register request is checked by counting rises of `debug_o` across the whole entry and the exit that follows.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_RST   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_FETCH = 3'd3,
    ST_WAKE  = 3'd4,
    ST_DBG   = 3'd5
  } dbg_state_e;
endpackage

// File: rtl/dbg_req_unit.sv
module dbg_req_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ext_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o,
  output logic req_o
);
  logic pend_q;

  // clear on entry wins over a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (clr_i)        pend_q <= 1'b0;
    else if (set_i && en_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
  assign req_o  = en_i && (!ext_ni || pend_q);
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_entry_pkg::*;
#(
  parameter int LpW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cpu_rst_ni,
  input  logic           en_i,
  input  logic           req_i,
  input  logic           go_i,
  input  logic           instr_done_i,
  input  logic           ir_loaded_i,
  input  logic [LpW-1:0] lp_i,
  input  logic           clk_run_i,
  output logic           enter_o,
  output logic           halt_o,
  output logic           wake_o,
  output logic           debug_o,
  output logic           rst_skip_o
);
  dbg_state_e state_q, state_d;
  logic       skip_q, skip_d;
  logic       lp_any;

  assign lp_any = |lp_i;

  always_comb begin
    state_d = state_q;
    if (!cpu_rst_ni) begin
      state_d = ST_RST;
    end else begin
      unique case (state_q)
        ST_RST:   state_d = (en_i && req_i) ? ST_DBG : ST_RUN;
        ST_RUN:   if (en_i && req_i) state_d = lp_any ? ST_WAKE : ST_DRAIN;
        ST_DRAIN: if (!en_i) state_d = ST_RUN;
                  else if (instr_done_i) state_d = ST_FETCH;
        ST_FETCH: if (!en_i) state_d = ST_RUN;
                  else if (ir_loaded_i) state_d = ST_DBG;
        ST_WAKE:  if (!en_i) state_d = ST_RUN;
                  else if (clk_run_i) state_d = ST_DBG;
        ST_DBG:   if (go_i) state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  assign enter_o = (state_d == ST_DBG) && (state_q != ST_DBG);

  always_comb begin
    skip_d = skip_q;
    if (state_d != ST_DBG)     skip_d = 1'b0;
    else if (state_q == ST_RST) skip_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      skip_q  <= skip_d;
    end
  end

  assign debug_o    = (state_q == ST_DBG);
  assign halt_o     = (state_q == ST_DBG);
  assign wake_o     = (state_q == ST_WAKE) || (state_q == ST_DBG);
  assign rst_skip_o = skip_q;
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int LpW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cpu_rst_ni,
  input  logic           dbg_en_i,
  input  logic           ext_req_ni,
  input  logic           reg_req_set_i,
  input  logic           go_i,
  input  logic           instr_done_i,
  input  logic           ir_loaded_i,
  input  logic [LpW-1:0] lp_i,
  input  logic           clk_run_i,
  output logic           halt_o,
  output logic           wake_o,
  output logic           debug_o,
  output logic           rst_skip_o,
  output logic           req_pend_o
);
  logic req, enter;

  dbg_req_unit u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dbg_en_i),
    .ext_ni (ext_req_ni),
    .set_i  (reg_req_set_i),
    .clr_i  (enter),
    .pend_o (req_pend_o),
    .req_o  (req)
  );

  dbg_entry_fsm #(.LpW(LpW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_rst_ni   (cpu_rst_ni),
    .en_i         (dbg_en_i),
    .req_i        (req),
    .go_i         (go_i),
    .instr_done_i (instr_done_i),
    .ir_loaded_i  (ir_loaded_i),
    .lp_i         (lp_i),
    .clk_run_i    (clk_run_i),
    .enter_o      (enter),
    .halt_o       (halt_o),
    .wake_o       (wake_o),
    .debug_o      (debug_o),
    .rst_skip_o   (rst_skip_o)
  );
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpu_rst_ni,
  input logic dbg_en_i,
  input logic go_i,
  input logic ir_loaded_i,
  input logic clk_run_i,
  input logic wake_o,
  input logic debug_o,
  input logic rst_skip_o,
  input logic req_pend_o
);
  // R1
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(debug_o) |-> $past(dbg_en_i));

  // R4
  fetch_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(debug_o) && !rst_skip_o && !$past(wake_o)) |-> $past(ir_loaded_i));

  // R6
  go_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_o && go_i && cpu_rst_ni) |=> !debug_o);

  // R7
  wake_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(debug_o) && $past(wake_o)) |-> $past(clk_run_i));

  // R8
  skip_only_on_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_skip_o) |-> $rose(debug_o));

  // R9
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(debug_o) |-> !req_pend_o);
endmodule

bind dbg_entry_ctrl dbg_entry_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_rst_ni  (cpu_rst_ni),
  .dbg_en_i    (dbg_en_i),
  .go_i        (go_i),
  .ir_loaded_i (ir_loaded_i),
  .clk_run_i   (clk_run_i),
  .wake_o      (wake_o),
  .debug_o     (debug_o),
  .rst_skip_o  (rst_skip_o),
  .req_pend_o  (req_pend_o)
);

// File: tb/sim_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_entry_ctrl;
  localparam int ClkPeriod = 10;
  localparam int LpW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, cpu_rst_ni = 1'b0, dbg_en = 1'b0, ext_n = 1'b1;
  logic reg_set = 1'b0, go = 1'b0, done = 1'b0, loaded = 1'b0, clk_run = 1'b0;
  logic [LpW-1:0] lp = '0;
  logic halt, wake, dbg, skip, pend;

  int total = 0, bad = 0, rises = 0;
  logic dbg_prev = 1'b0;
  bit finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  dbg_entry_ctrl #(.LpW(LpW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_rst_ni(cpu_rst_ni), .dbg_en_i(dbg_en),
    .ext_req_ni(ext_n), .reg_req_set_i(reg_set), .go_i(go),
    .instr_done_i(done), .ir_loaded_i(loaded), .lp_i(lp), .clk_run_i(clk_run),
    .halt_o(halt), .wake_o(wake), .debug_o(dbg), .rst_skip_o(skip),
    .req_pend_o(pend)
  );

  always @(negedge clk) begin
    if (dbg && !dbg_prev) rises++;
    dbg_prev = dbg;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_go();
    go = 1'b1; cyc(); go = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R6", "halt in reset", halt, 1'b0);
    chk("R6", "debug in reset", dbg, 1'b0);
    chk("R6", "wake in reset", wake, 1'b0);
    chk("R6", "skip in reset", skip, 1'b0);
    chk("R6", "pend in reset", pend, 1'b0);
    rst_ni = 1'b1; cyc(2);
  endtask

  task automatic t_ext_reset();
    dbg_en = 1'b1; ext_n = 1'b0; cpu_rst_ni = 1'b0; cyc(3);
    cpu_rst_ni = 1'b1; cyc();
    chk("R2", "debug after release", dbg, 1'b1);
    chk("R2", "halt after release", halt, 1'b1);
    chk("R2", "skip flag", skip, 1'b1);
    chk("R6", "wake in debug", wake, 1'b1);
    ext_n = 1'b1; cyc();
    pulse_go();
    chk("R6", "debug after go", dbg, 1'b0);
    chk("R6", "halt after go", halt, 1'b0);
    chk("R6", "wake after go", wake, 1'b0);
    chk("R6", "skip after go", skip, 1'b0);
    cyc(2);
    chk("R6", "stays running", dbg, 1'b0);
  endtask

  task automatic t_reg_reset();
    cpu_rst_ni = 1'b0; cyc();
    reg_set = 1'b1; cyc(); reg_set = 1'b0; cyc();
    chk("R3", "pend in reset", pend, 1'b1);
    chk("R3", "no debug yet", dbg, 1'b0);
    cpu_rst_ni = 1'b1; cyc();
    chk("R3", "debug after release", dbg, 1'b1);
    chk("R3", "skip flag", skip, 1'b1);
    chk("R9", "pend cleared", pend, 1'b0);
    pulse_go(); cyc(3);
    chk("R9", "no reentry", dbg, 1'b0);
  endtask

  task automatic t_normal();
    ext_n = 1'b0; cyc(); ext_n = 1'b1;
    cyc(2);
    chk("R4", "no halt before done", halt, 1'b0);
    loaded = 1'b1; cyc(); loaded = 1'b0; cyc();
    chk("R5", "early fetch ignored", halt, 1'b0);
    done = 1'b1; cyc(); done = 1'b0; cyc(2);
    chk("R4", "waits for fetch", dbg, 1'b0);
    loaded = 1'b1; cyc(); loaded = 1'b0;
    chk("R4", "debug after fetch", dbg, 1'b1);
    chk("R4", "halt after fetch", halt, 1'b1);
    chk("R8", "no skip on normal entry", skip, 1'b0);
    pulse_go();
    chk("R6", "exit normal", dbg, 1'b0);
  endtask

  task automatic t_lowpower();
    lp = 3'b100; clk_run = 1'b0;
    reg_set = 1'b1; cyc(); reg_set = 1'b0;
    chk("R7", "pend set", pend, 1'b1);
    chk("R7", "no wake yet", wake, 1'b0);
    cyc();
    chk("R7", "wake raised", wake, 1'b1);
    chk("R7", "not debug while clocks off", dbg, 1'b0);
    cyc(3);
    chk("R7", "still waiting", dbg, 1'b0);
    clk_run = 1'b1; cyc();
    chk("R7", "debug after clocks run", dbg, 1'b1);
    chk("R9", "pend cleared", pend, 1'b0);
    chk("R8", "no skip from low power", skip, 1'b0);
    lp = '0; pulse_go(); clk_run = 1'b0;
    chk("R6", "exit low power", wake, 1'b0);
  endtask

  task automatic t_both();
    int r0;
    r0 = rises;
    ext_n = 1'b0; reg_set = 1'b1; cyc(); reg_set = 1'b0;
    done = 1'b1; cyc(); done = 1'b0;
    loaded = 1'b1; cyc(); loaded = 1'b0;
    chk("R10", "entered", dbg, 1'b1);
    ext_n = 1'b1; cyc();
    pulse_go(); cyc(4);
    chk("R10", "no second entry", dbg, 1'b0);
    chk("R10", "pend clear", pend, 1'b0);
    chk("R10", "single rise", (rises - r0) == 1, 1'b1);
  endtask

  task automatic t_disabled();
    dbg_en = 1'b0; ext_n = 1'b0; reg_set = 1'b1; cyc(); reg_set = 1'b0;
    chk("R1", "reg set ignored", pend, 1'b0);
    done = 1'b1; cyc(); done = 1'b0; loaded = 1'b1; cyc(); loaded = 1'b0;
    lp = 3'b001; clk_run = 1'b1; cyc(3);
    chk("R1", "no halt", halt, 1'b0);
    chk("R1", "no wake", wake, 1'b0);
    lp = '0; clk_run = 1'b0;
    cpu_rst_ni = 1'b0; cyc(2); cpu_rst_ni = 1'b1; cyc(2);
    chk("R1", "no reset entry", dbg, 1'b0);
    ext_n = 1'b1; dbg_en = 1'b1;
    ext_n = 1'b0; cyc(); ext_n = 1'b1; cyc();
    dbg_en = 1'b0; cyc();
    done = 1'b1; cyc(); done = 1'b0; loaded = 1'b1; cyc(); loaded = 1'b0; cyc();
    chk("R1", "abort on disable", dbg, 1'b0);
    dbg_en = 1'b1; cyc(3);
    chk("R1", "idle after abort", halt, 1'b0);
  endtask

  initial begin
    cyc(2);
    t_reset_state();
    t_ext_reset();
    t_reg_reset();
    t_normal();
    t_lowpower();
    t_both();
    t_disabled();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule